// File: doc/BRIEF.md
# Stall Skid Buffer with Result Replay

This block sits at the exit of a pipelined function unit whose stages cannot be frozen. The unit produces a result a fixed number of cycles after issue, and operations already in flight keep arriving even after the core has asserted stall. While stall is high, the block captures the unit's exit slot every cycle into a small shift-ordered buffer. It does not filter on valid, so empty slots ("holes") are stored too. When stall drops, the captured results are handed back to the consumers in age order. The operations are not issued again; their results are retired a second time.

Every stored entry carries a valid bit, a live bit, the frame it belongs to, and its data. A result whose frame has already been exited arrives marked dead. A per-cycle kill request names a frame and clears the live bit of every entry of that frame. While the core is stalled, a drain request moves the oldest entry out toward a slower backing store. Only entries that are valid and live reach the spill port; all others are freed silently. During replay, holes and dead entries are stepped over in the same cycle as the next result, so they cost no replay cycles.

Top module: `skid_replay_buffer`

## Requirements
- R1: After synchronous reset the buffer is empty, and both out_valid_o and spill_valid_o are low while no result is presented.
- R2: With stall low and no replayable entry stored, an incoming result is forwarded to the out port in the same cycle. out_valid_o is then res_valid_i AND live-on-arrival.
- R3: While stall_i is high, out_valid_o is low, and the unit's exit slot is appended to the buffer every cycle whether res_valid_i is set or not.
- R4: After stall falls, stored results that are both valid and live appear on the out port one per cycle, oldest first. New unit outputs that arrive meanwhile are queued behind them. The stored count never grows during a cycle with stall low.
- R5: Holes (valid=0) and dead entries between replayable results are skipped in the same cycle as the next replayable result, adding no replay cycles.
- R6: A result presented with res_dead_i=1 is never forwarded, replayed or spilled.
- R7: A kill with frame f clears live on every stored entry of frame f and on an incoming result of frame f. It takes effect in the cycle it is presented, so no out or spill pulse carries frame f in that cycle or later.
- R8: With stall_i and drain_i both high and the buffer not empty, the oldest entry is removed in that cycle. spill_valid_o pulses with its data and frame only if the entry is valid and live; spill_valid_o is never high otherwise.
- R9: Capacity is LAT + STALL_DLY entries. A full stall window of that many slots is held and replayed intact. A stalled cycle without drain on a full buffer is an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Core stall; captures unit output while high |
| drain_i | input | 1 | Move oldest entry toward backing store (acts while stalled) |
| res_valid_i | input | 1 | Unit exit slot holds a result |
| res_data_i | input | SKID_DATA_W | Result data |
| res_frame_i | input | SKID_FRAME_W | Frame the result belongs to |
| res_dead_i | input | 1 | Result belongs to an exited frame |
| kill_valid_i | input | 1 | Kill request present |
| kill_frame_i | input | SKID_FRAME_W | Frame whose entries lose liveness |
| out_valid_o | output | 1 | Result retired toward consumers |
| out_data_o | output | SKID_DATA_W | Retired result data |
| out_frame_o | output | SKID_FRAME_W | Retired result frame |
| spill_valid_o | output | 1 | Live entry moved to backing store |
| spill_data_o | output | SKID_DATA_W | Spilled data |
| spill_frame_o | output | SKID_FRAME_W | Spilled frame |

## Verification
The bench builds the block with its defaults, LAT=4 and STALL_DLY=2, which gives six entries and a 3-bit frame. With so few entries, random stall runs regularly fill the buffer to capacity. The random streams also pack holes, kills and dead arrivals among stored entries, which exercises multi-entry skips and drain on a full buffer. Eight frame values make kills match stored entries often.

// File: rtl/skid_pkg.sv
package skid_pkg;

    parameter int SKID_DATA_W  = 16;
    parameter int SKID_FRAME_W = 3;

    typedef logic [SKID_DATA_W-1:0]  data_t;
    typedef logic [SKID_FRAME_W-1:0] frame_t;

    typedef struct packed {
        logic   valid;
        logic   live;
        frame_t frame;
        data_t  data;
    } skid_entry_t;

    // An entry can be retired or spilled when it holds a result that no
    // kill (including one presented this cycle) has removed.
    function automatic logic entry_alive(skid_entry_t e, logic kv, frame_t kf);
        return e.valid && e.live && !(kv && (kf == e.frame));
    endfunction

endpackage

// File: rtl/skid_store.sv
module skid_store
    import skid_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        kill_v,
    input  frame_t      kill_f,
    input  logic [CW-1:0] pop_n,
    input  logic        push,
    input  skid_entry_t push_e,
    output skid_entry_t ents [DEPTH],
    output logic [CW-1:0] count
);

    skid_entry_t q   [DEPTH];
    skid_entry_t nxt [DEPTH];
    logic [CW-1:0] cnt_q, cnt_nxt;

    always_comb begin
        int wpos;
        for (int i = 0; i < DEPTH; i++) begin
            if (i + int'(pop_n) < DEPTH) nxt[i] = q[i + int'(pop_n)];
            else                         nxt[i] = '0;
            if (kill_v && nxt[i].frame == kill_f) nxt[i].live = 1'b0;
        end
        wpos    = int'(cnt_q) - int'(pop_n);
        cnt_nxt = CW'(wpos);
        if (push && wpos < DEPTH) begin
            for (int i = 0; i < DEPTH; i++)
                if (i == wpos) nxt[i] = push_e;
            cnt_nxt = CW'(wpos + 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) q[i] <= '0;
        end else begin
            cnt_q <= cnt_nxt;
            for (int i = 0; i < DEPTH; i++) q[i] <= nxt[i];
        end
    end

    assign count = cnt_q;
    assign ents  = q;

endmodule

// File: rtl/skid_pick.sv
module skid_pick
    import skid_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  skid_entry_t   ents [DEPTH],
    input  logic [CW-1:0] count,
    input  logic          kill_v,
    input  frame_t        kill_f,
    output logic          found,
    output logic [CW-1:0] idx
);

    logic [DEPTH-1:0] ready;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ready
        assign ready[g] = (g < int'(count)) && entry_alive(ents[g], kill_v, kill_f);
    end

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (ready[i]) begin
                found = 1'b1;
                idx   = CW'(i);
            end
        end
    end

endmodule

// File: rtl/skid_replay_buffer.sv
module skid_replay_buffer
    import skid_pkg::*;
#(
    parameter int LAT       = 4,
    parameter int STALL_DLY = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   stall_i,
    input  logic   drain_i,
    input  logic   res_valid_i,
    input  data_t  res_data_i,
    input  frame_t res_frame_i,
    input  logic   res_dead_i,
    input  logic   kill_valid_i,
    input  frame_t kill_frame_i,
    output logic   out_valid_o,
    output data_t  out_data_o,
    output frame_t out_frame_o,
    output logic   spill_valid_o,
    output data_t  spill_data_o,
    output frame_t spill_frame_o
);

    localparam int DEPTH = LAT + STALL_DLY;
    localparam int CW    = $clog2(DEPTH + 1);

    skid_entry_t   ents [DEPTH];
    skid_entry_t   in_e;
    logic [CW-1:0] count_q;
    logic [CW-1:0] pop_n;
    logic          push;
    logic          found;
    logic [CW-1:0] pick_idx;

    skid_store #(.DEPTH(DEPTH), .CW(CW)) u_store (
        .clk    (clk),
        .rst    (rst),
        .kill_v (kill_valid_i),
        .kill_f (kill_frame_i),
        .pop_n  (pop_n),
        .push   (push),
        .push_e (in_e),
        .ents   (ents),
        .count  (count_q)
    );

    skid_pick #(.DEPTH(DEPTH), .CW(CW)) u_pick (
        .ents   (ents),
        .count  (count_q),
        .kill_v (kill_valid_i),
        .kill_f (kill_frame_i),
        .found  (found),
        .idx    (pick_idx)
    );

    always_comb begin
        in_e.valid = res_valid_i;
        in_e.live  = !res_dead_i && !(kill_valid_i && kill_frame_i == res_frame_i);
        in_e.frame = res_frame_i;
        in_e.data  = res_data_i;
    end

    always_comb begin
        pop_n         = '0;
        push          = 1'b0;
        out_valid_o   = 1'b0;
        out_data_o    = res_data_i;
        out_frame_o   = res_frame_i;
        spill_valid_o = 1'b0;
        spill_data_o  = ents[0].data;
        spill_frame_o = ents[0].frame;
        if (stall_i) begin
            push = 1'b1;
            if (drain_i && count_q != '0) begin
                pop_n         = CW'(1);
                spill_valid_o = entry_alive(ents[0], kill_valid_i, kill_frame_i);
            end
        end else if (found) begin
            out_valid_o = 1'b1;
            out_data_o  = ents[pick_idx].data;
            out_frame_o = ents[pick_idx].frame;
            pop_n       = pick_idx + CW'(1);
            push        = 1'b1;
        end else begin
            pop_n       = count_q;
            out_valid_o = res_valid_i && in_e.live;
        end
    end

endmodule

// File: rtl/skid_chk.sv
module skid_chk
    import skid_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          stall_i,
    input logic          drain_i,
    input logic          kill_valid_i,
    input frame_t        kill_frame_i,
    input logic          out_valid_o,
    input frame_t        out_frame_o,
    input logic          spill_valid_o,
    input frame_t        spill_frame_o,
    input logic [CW-1:0] count
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (stall_i && !drain_i) |-> (int'(count) < DEPTH)); // R9

    AST_QUIET_STALL: assert property (@(posedge clk) disable iff (rst)
        stall_i |-> !out_valid_o); // R3

    AST_NO_GROWTH: assert property (@(posedge clk) disable iff (rst)
        !stall_i |=> (count <= $past(count))); // R4

    AST_SPILL_GATED: assert property (@(posedge clk) disable iff (rst)
        spill_valid_o |-> (stall_i && drain_i)); // R8

    AST_KILL_OUT: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && kill_valid_i) |-> (out_frame_o != kill_frame_i)); // R7

    AST_KILL_SPILL: assert property (@(posedge clk) disable iff (rst)
        (spill_valid_o && kill_valid_i) |-> (spill_frame_o != kill_frame_i)); // R7

endmodule

bind skid_replay_buffer skid_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .stall_i       (stall_i),
    .drain_i       (drain_i),
    .kill_valid_i  (kill_valid_i),
    .kill_frame_i  (kill_frame_i),
    .out_valid_o   (out_valid_o),
    .out_frame_o   (out_frame_o),
    .spill_valid_o (spill_valid_o),
    .spill_frame_o (spill_frame_o),
    .count         (count_q)
);

// File: tb/skid_replay_buffer_tb.sv
module skid_replay_buffer_tb;
    import skid_pkg::*;

    localparam int LAT   = 4;
    localparam int SDLY  = 2;
    localparam int DEPTH = LAT + SDLY;

    logic   clk = 1'b0;
    logic   rst = 1'b1;
    logic   stall_i = 0, drain_i = 0, res_valid_i = 0, res_dead_i = 0, kill_valid_i = 0;
    data_t  res_data_i = '0;
    frame_t res_frame_i = '0, kill_frame_i = '0;
    logic   out_valid_o, spill_valid_o;
    data_t  out_data_o, spill_data_o;
    frame_t out_frame_o, spill_frame_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference state
    logic   mv [DEPTH];
    logic   ml [DEPTH];
    frame_t mf [DEPTH];
    data_t  md [DEPTH];
    int     mcnt = 0;

    always #4 clk = ~clk;

    skid_replay_buffer #(.LAT(LAT), .STALL_DLY(SDLY)) u_dut (
        .clk(clk), .rst(rst), .stall_i(stall_i), .drain_i(drain_i),
        .res_valid_i(res_valid_i), .res_data_i(res_data_i), .res_frame_i(res_frame_i),
        .res_dead_i(res_dead_i), .kill_valid_i(kill_valid_i), .kill_frame_i(kill_frame_i),
        .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_frame_o(out_frame_o),
        .spill_valid_o(spill_valid_o), .spill_data_o(spill_data_o), .spill_frame_o(spill_frame_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit m_alive(int i, logic kv, frame_t kf);
        return (i < mcnt) && mv[i] && ml[i] && !(kv && kf == mf[i]);
    endfunction

    task automatic m_drop(int n);
        for (int i = 0; i < DEPTH; i++) begin
            if (i + n < DEPTH) begin
                mv[i] = mv[i+n]; ml[i] = ml[i+n]; mf[i] = mf[i+n]; md[i] = md[i+n];
            end
        end
        mcnt -= n;
    endtask

    task automatic step(input logic st, input logic dr, input logic rv, input data_t rd,
                        input frame_t rf, input logic rdead, input logic kv,
                        input frame_t kf, input string tag);
        bit     e_out, e_sp, in_live;
        data_t  e_d, e_sd;
        frame_t e_f, e_sf;
        int     k;
        string  t;
        @(negedge clk);
        stall_i = st; drain_i = dr; res_valid_i = rv; res_data_i = rd;
        res_frame_i = rf; res_dead_i = rdead; kill_valid_i = kv; kill_frame_i = kf;
        #1;
        in_live = !rdead && !(kv && kf == rf);
        e_out = 0; e_sp = 0; e_d = '0; e_f = '0; e_sd = '0; e_sf = '0;
        k = -1;
        for (int i = DEPTH - 1; i >= 0; i--) if (m_alive(i, kv, kf)) k = i;
        if (st)       t = (dr && mcnt > 0) ? "R8" : "R3";
        else if (k >= 0) t = "R4";
        else          t = (rdead || kv) ? "R6" : "R2";
        if (tag != "") t = tag;
        if (st) begin
            if (dr && mcnt > 0) begin
                e_sp = m_alive(0, kv, kf); e_sd = md[0]; e_sf = mf[0];
            end
        end else if (k >= 0) begin
            e_out = 1; e_d = md[k]; e_f = mf[k];
        end else begin
            e_out = rv && in_live; e_d = rd; e_f = rf;
        end
        chk(out_valid_o == e_out, t, "out_valid", out_valid_o, e_out);
        if (e_out && out_valid_o) begin
            chk(out_data_o == e_d, t, "out_data", out_data_o, e_d);
            chk(out_frame_o == e_f, t, "out_frame", out_frame_o, e_f);
        end
        chk(spill_valid_o == e_sp, t, "spill_valid", spill_valid_o, e_sp);
        if (e_sp && spill_valid_o) begin
            chk(spill_data_o == e_sd, t, "spill_data", spill_data_o, e_sd);
            chk(spill_frame_o == e_sf, t, "spill_frame", spill_frame_o, e_sf);
        end
        // advance the reference to the state after the coming edge
        for (int i = 0; i < DEPTH; i++) if (i < mcnt && kv && mf[i] == kf) ml[i] = 0;
        if (st) begin
            if (dr && mcnt > 0) m_drop(1);
            if (mcnt < DEPTH) begin
                mv[mcnt] = rv; ml[mcnt] = in_live; mf[mcnt] = rf; md[mcnt] = rd; mcnt++;
            end
        end else if (k >= 0) begin
            m_drop(k + 1);
            mv[mcnt] = rv; ml[mcnt] = in_live; mf[mcnt] = rf; md[mcnt] = rd; mcnt++;
        end else begin
            mcnt = 0;
        end
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, '0, '0, 0, 0, '0, tag);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) begin mv[i] = 0; ml[i] = 0; mf[i] = '0; md[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: empty after reset, no pulses; drain on empty spills nothing
        idle("R1");
        step(1, 1, 0, '0, '0, 0, 0, '0, "R1");
        idle("R1");

        // R2: direct forward with nothing stored
        step(0, 0, 1, 16'hA001, 3'd1, 0, 0, '0, "R2");

        // R5: valid, hole, hole, valid captured; replay with no hole cycles
        step(1, 0, 1, 16'hB001, 3'd2, 0, 0, '0, "R3");
        step(1, 0, 0, 16'h0000, 3'd2, 0, 0, '0, "R3");
        step(1, 0, 0, 16'h0000, 3'd2, 0, 0, '0, "R3");
        step(1, 0, 1, 16'hB002, 3'd2, 0, 0, '0, "R3");
        step(0, 0, 1, 16'hB003, 3'd2, 0, 0, '0, "R5");
        step(0, 0, 0, '0, '0, 0, 0, '0, "R5");
        step(0, 0, 0, '0, '0, 0, 0, '0, "R4");
        idle("R2");

        // R6: dead arrival neither stored for replay nor forwarded
        step(1, 0, 1, 16'hC001, 3'd3, 1, 0, '0, "R6");
        step(1, 0, 1, 16'hC002, 3'd3, 0, 0, '0, "R6");
        step(0, 0, 1, 16'hC003, 3'd3, 1, 0, '0, "R6");
        idle("R6");
        idle("R6");

        // R7: kill frame 2 while stalled, then at release
        step(1, 0, 1, 16'hD001, 3'd2, 0, 0, '0, "R7");
        step(1, 0, 1, 16'hD002, 3'd5, 0, 1, 3'd2, "R7");
        step(1, 0, 1, 16'hD003, 3'd2, 0, 0, '0, "R7");
        step(0, 0, 0, '0, '0, 0, 1, 3'd2, "R7");
        idle("R7");

        // R8: drain while stalled: live spills, dead freed silently
        step(1, 0, 1, 16'hE001, 3'd4, 0, 0, '0, "R8");
        step(1, 0, 1, 16'hE002, 3'd4, 1, 0, '0, "R8");
        step(1, 0, 0, 16'h0000, 3'd4, 0, 0, '0, "R8");
        step(1, 1, 0, '0, '0, 0, 0, '0, "R8");
        step(1, 1, 0, '0, '0, 0, 0, '0, "R8");
        step(1, 1, 0, '0, '0, 0, 0, '0, "R8");
        step(1, 1, 0, '0, '0, 0, 0, '0, "R8");
        idle("R8");
        idle("R8");

        // R9: fill to capacity in one stall window and replay all of it
        for (int i = 0; i < DEPTH; i++)
            step(1, 0, 1, data_t'(16'hF000 + i), frame_t'(i), 0, 0, '0, "R9");
        for (int i = 0; i < DEPTH + 2; i++)
            idle("R9");

        // mixed random traffic
        for (int n = 0; n < 4000; n++) begin
            logic st, dr;
            st = ($urandom % 100) < 45;
            dr = st && (($urandom % 4) == 0);
            if (st && mcnt >= DEPTH) dr = 1;
            step(st, dr, ($urandom % 4) != 0, data_t'($urandom), frame_t'($urandom),
                 ($urandom % 8) == 0, ($urandom % 10) == 0, frame_t'($urandom), "");
        end
        for (int i = 0; i < DEPTH + 2; i++) idle("");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule